// File: doc/BRIEF.md
# SDLC Receive Frame CRC Checker

This block checks the frame check sequence of a bit-oriented synchronous receiver. It sits behind the deframer. The deframer has already located the flags and removed the stuffed zeros, and it hands this block one payload bit per `bitValid` strobe, together with indications for a flag, for hunt state and for a checker-reset command. Every bit between two flags goes through a serial CRC-CCITT register. The two trailing check bytes are included. The transmitter sends its check bytes complemented, so a clean frame always leaves the same non-zero remainder, 16'h1D0F, whatever the preset was.

When a closing flag arrives, the block latches a pass/fail result and a 3-bit residue code and pulses `frameDone` for one cycle. The residue code tells software where the information field ends relative to the last character boundary. Both results hold until the next frame end. Software should read `crcError` only together with the `frameDone` pulse, or later from its held value.

The register is preset automatically on every flag and throughout hunt state. An explicit reset command also presets it. The preset is all ones or all zeros, chosen by `presetOnes`.

Top module: `sdlc_rx_crc_check`

## Requirements
- R1: Each accepted bit is shifted into a 16-bit register with polynomial x^16+x^12+x^5+1. The feedback is the incoming bit XOR register bit 15, and the register shifts toward bit 15. Characters arrive least significant bit first. A frame whose last 16 bits are the complement of the running remainder (bit 15 first) ends with remainder 16'h1D0F and reports `crcError`=0.
- R2: If the remainder at the closing flag is anything other than 16'h1D0F, `crcError` is 1. This includes any single flipped bit in the data or check field.
- R3: Whenever the register is preset, it loads all ones if `presetOnes`=1 and all zeros if `presetOnes`=0. A frame generated from one preset and checked with the other preset fails.
- R4: Every `flagSeen` cycle presets the register. Frames follow one another with no other reset.
- R5: Every cycle with `huntActive`=1 presets the register and abandons the frame in progress. A flag after hunt with no new bits produces no `frameDone`.
- R6: `crcReset` presets the register without clearing the count of bits received since the last flag.
- R7: A `flagSeen` cycle that comes after at least one accepted bit since the previous flag (with `huntActive`=0) is a closing flag. On the next clock edge `frameDone` is 1 for exactly one cycle. A flag with no bits since the previous flag is an opening flag and gives no `frameDone`.
- R8: `crcError` and `residue` change only with `frameDone`. They hold their values through later bits, flags and hunt.
- R9: `residue` comes from n = (bits accepted since the opening flag) mod 8, looked up as n=0:011, 1:000, 2:100, 3:010, 4:110, 5:001, 6:111, 7:101. Code 101 therefore means the information field ended 7 bits into its character.
- R10: `bitValid` is ignored in any cycle where `flagSeen`, `huntActive` or `crcReset` is 1. Such a bit changes neither the remainder nor the bit count.
- R11: After reset, `frameDone`, `crcError` and `residue` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | A payload bit is present on bitData |
| bitData | input | 1 | Unstuffed payload bit |
| flagSeen | input | 1 | Deframer recognised a flag this cycle |
| huntActive | input | 1 | Receiver is hunting for a flag |
| presetOnes | input | 1 | Preset select: 1 = all ones, 0 = all zeros |
| crcReset | input | 1 | Command to preset the checker now |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| crcError | output | 1 | Latched CRC result, 1 = bad frame |
| residue | output | 3 | Latched residue code |

## Verification
The assertions check several rules on every cycle:
- every preset source (flag, hunt, command) leaves the register at the selected preset value on the next cycle;
- `frameDone` only follows a non-hunt flag and is never two cycles long;
- the latched results never move without `frameDone`.

Other behaviour can only be shown by the bench's scenarios: that real frames pass, that every single-bit corruption fails, that mismatched presets fail, the full residue table, and that bits coincident with a flag, hunt or reset command are dropped from the count. The bench shows these by comparing against its own CRC model.

// File: rtl/sdlc_crc_pkg.sv
package sdlc_crc_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] GOOD_REMAINDER = 16'h1D0F;
  localparam int CHAR_BITS = 8;
  localparam int RES_W = 3;
  // codes for phase 7 down to phase 0
  localparam logic [CHAR_BITS*RES_W-1:0] RESIDUE_MAP =
    {3'b101, 3'b111, 3'b001, 3'b110, 3'b010, 3'b100, 3'b000, 3'b011};

  typedef struct packed {
    logic preset;  // load preset value into the remainder register
    logic shift;   // accept one payload bit
    logic latch;   // closing flag: capture result and residue
  } crcStrobes_t;
endpackage

// File: rtl/sdlc_crc_ctrl.sv
module sdlc_crc_ctrl
  import sdlc_crc_pkg::*;
#(
  parameter int CHAR_BITS_P = CHAR_BITS,
  localparam int CNT_W = (CHAR_BITS_P > 1) ? $clog2(CHAR_BITS_P) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             flagSeen,
  input  logic             huntActive,
  input  logic             crcReset,
  output crcStrobes_t      stb,
  output logic [CNT_W-1:0] bitPhase,
  output logic             frameDone
);
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(CHAR_BITS_P - 1);

  logic             inFrame;
  logic [CNT_W-1:0] phaseQ;
  logic             doneQ;

  always_comb begin
    stb.preset = huntActive | flagSeen | crcReset;
    stb.shift  = bitValid & ~stb.preset;
    stb.latch  = flagSeen & ~huntActive & inFrame;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      phaseQ  <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= stb.latch;
      if (huntActive || flagSeen) begin
        inFrame <= 1'b0;
        phaseQ  <= '0;
      end else if (stb.shift) begin
        inFrame <= 1'b1;
        phaseQ  <= (phaseQ == LAST_PHASE) ? '0 : phaseQ + 1'b1;
      end
    end
  end

  assign bitPhase  = phaseQ;
  assign frameDone = doneQ;
endmodule

// File: rtl/sdlc_crc_datapath.sv
module sdlc_crc_datapath
  import sdlc_crc_pkg::*;
#(
  parameter int                        WIDTH       = CRC_W,
  parameter logic [WIDTH-1:0]          POLY        = CRC_POLY,
  parameter logic [WIDTH-1:0]          GOOD_REM    = GOOD_REMAINDER,
  parameter int                        CHAR_BITS_P = CHAR_BITS,
  parameter int                        RES_W_P     = RES_W,
  parameter logic [CHAR_BITS_P*RES_W_P-1:0] RES_MAP = RESIDUE_MAP,
  localparam int CNT_W = (CHAR_BITS_P > 1) ? $clog2(CHAR_BITS_P) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  crcStrobes_t        stb,
  input  logic               bitData,
  input  logic               presetOnes,
  input  logic [CNT_W-1:0]   bitPhase,
  output logic [WIDTH-1:0]   crcState,
  output logic               crcError,
  output logic [RES_W_P-1:0] residue
);
  logic [WIDTH-1:0]   crcQ;
  logic [WIDTH-1:0]   crcNext;
  logic               feedback;
  logic [RES_W_P-1:0] resLookup;

  assign feedback = bitData ^ crcQ[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign crcNext[i] = POLY[i] & feedback;
    end else begin : g_high
      assign crcNext[i] = crcQ[i-1] ^ (POLY[i] & feedback);
    end
  end

  always_comb begin
    resLookup = RES_MAP[int'(bitPhase)*RES_W_P +: RES_W_P];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ     <= '1;
      crcError <= 1'b0;
      residue  <= '0;
    end else begin
      if (stb.latch) begin
        crcError <= (crcQ != GOOD_REM);
        residue  <= resLookup;
      end
      if (stb.preset) begin
        crcQ <= presetOnes ? '1 : '0;
      end else if (stb.shift) begin
        crcQ <= crcNext;
      end
    end
  end

  assign crcState = crcQ;
endmodule

// File: rtl/sdlc_rx_crc_check.sv
module sdlc_rx_crc_check
  import sdlc_crc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       bitData,
  input  logic       flagSeen,
  input  logic       huntActive,
  input  logic       presetOnes,
  input  logic       crcReset,
  output logic       frameDone,
  output logic       crcError,
  output logic [2:0] residue
);
  localparam int CNT_W = (CHAR_BITS > 1) ? $clog2(CHAR_BITS) : 1;

  crcStrobes_t      stb;
  logic [CNT_W-1:0] bitPhase;
  logic [CRC_W-1:0] crcState;

  sdlc_crc_ctrl #(.CHAR_BITS_P(CHAR_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitValid  (bitValid),
    .flagSeen  (flagSeen),
    .huntActive(huntActive),
    .crcReset  (crcReset),
    .stb       (stb),
    .bitPhase  (bitPhase),
    .frameDone (frameDone)
  );

  sdlc_crc_datapath #(
    .WIDTH      (CRC_W),
    .POLY       (CRC_POLY),
    .GOOD_REM   (GOOD_REMAINDER),
    .CHAR_BITS_P(CHAR_BITS),
    .RES_W_P    (RES_W),
    .RES_MAP    (RESIDUE_MAP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .bitData   (bitData),
    .presetOnes(presetOnes),
    .bitPhase  (bitPhase),
    .crcState  (crcState),
    .crcError  (crcError),
    .residue   (residue)
  );
endmodule

// File: rtl/sdlc_rx_crc_check_sva.sv
module sdlc_rx_crc_check_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         flagSeen,
  input logic         huntActive,
  input logic         presetOnes,
  input logic         crcReset,
  input logic         frameDone,
  input logic         crcError,
  input logic [2:0]   residue,
  input logic [W-1:0] crcState
);
  // R4: a flag leaves the register at the selected preset
  a_r4_flag_preset: assert property (@(posedge clk) disable iff (!rstN)
    $past(flagSeen) |-> crcState == {W{$past(presetOnes)}});

  // R5: hunt leaves the register at the selected preset
  a_r5_hunt_preset: assert property (@(posedge clk) disable iff (!rstN)
    $past(huntActive) |-> crcState == {W{$past(presetOnes)}});

  // R6 and R3: reset command loads all ones or all zeros per presetOnes
  a_r6_cmd_preset: assert property (@(posedge clk) disable iff (!rstN)
    $past(crcReset) |-> crcState == {W{$past(presetOnes)}});

  // R7: end of frame only follows a flag seen outside hunt
  a_r7_done_source: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(flagSeen) && !$past(huntActive)));

  // R7: end-of-frame pulse lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R8: results move only together with frameDone
  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |-> ($stable(crcError) && $stable(residue)));
endmodule

bind sdlc_rx_crc_check sdlc_rx_crc_check_sva #(.W(16)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .flagSeen  (flagSeen),
  .huntActive(huntActive),
  .presetOnes(presetOnes),
  .crcReset  (crcReset),
  .frameDone (frameDone),
  .crcError  (crcError),
  .residue   (residue),
  .crcState  (crcState)
);

// File: tb/test_sdlc_rx_crc_check.sv
module test_sdlc_rx_crc_check;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0, bitData = 1'b0, flagSeen = 1'b0;
  logic huntActive = 1'b0, presetOnes = 1'b1, crcReset = 1'b0;
  logic frameDone, crcError;
  logic [2:0] residue;

  int checks = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #4 clk = ~clk;  // 125 MHz

  sdlc_rx_crc_check i_sdlc_rx_crc_check (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .flagSeen(flagSeen), .huntActive(huntActive), .presetOnes(presetOnes),
    .crcReset(crcReset), .frameDone(frameDone), .crcError(crcError),
    .residue(residue)
  );

  typedef struct packed {
    logic [7:0] nData;
    logic       genPre;
    logic       chkPre;
    logic [7:0] flip;   // 255 = no corruption
    logic       expErr;
    logic [2:0] expRes;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{8'd8,  1'b1, 1'b1, 8'd255, 1'b0, 3'b011},  // R1 R9 n=0
    '{8'd9,  1'b0, 1'b0, 8'd255, 1'b0, 3'b000},  // R3 R9 n=1
    '{8'd10, 1'b1, 1'b1, 8'd255, 1'b0, 3'b100},  // R9 n=2
    '{8'd11, 1'b0, 1'b0, 8'd255, 1'b0, 3'b010},  // R9 n=3
    '{8'd12, 1'b1, 1'b1, 8'd255, 1'b0, 3'b110},  // R9 n=4
    '{8'd13, 1'b0, 1'b0, 8'd255, 1'b0, 3'b001},  // R9 n=5
    '{8'd14, 1'b1, 1'b1, 8'd255, 1'b0, 3'b111},  // R9 n=6
    '{8'd15, 1'b1, 1'b1, 8'd255, 1'b0, 3'b101},  // R9 n=7
    '{8'd32, 1'b1, 1'b1, 8'd5,   1'b1, 3'b011},  // R2 data flip
    '{8'd24, 1'b0, 1'b0, 8'd30,  1'b1, 3'b011},  // R2 check-field flip
    '{8'd16, 1'b1, 1'b0, 8'd255, 1'b1, 3'b011},  // R3 preset mismatch
    '{8'd40, 1'b0, 1'b1, 8'd255, 1'b1, 3'b011},  // R3 preset mismatch
    '{8'd1,  1'b1, 1'b1, 8'd255, 1'b0, 3'b000},  // R1 shortest data
    '{8'd64, 1'b0, 1'b0, 8'd0,   1'b1, 3'b011}   // R2 first bit flip
  };

  function automatic logic [2:0] expResidue(input int nBits);
    case (nBits % 8)
      0: return 3'b011;
      1: return 3'b000;
      2: return 3'b100;
      3: return 3'b010;
      4: return 3'b110;
      5: return 3'b001;
      6: return 3'b111;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    logic fb;
    fb = b ^ c[15];
    c = {c[14:0], 1'b0};
    if (fb) c = c ^ 16'h1021;
    return c;
  endfunction

  function automatic logic nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic d, input logic f, input logic h,
                      input logic r);
    @(negedge clk);
    bitValid = v; bitData = d; flagSeen = f; huntActive = h; crcReset = r;
    @(posedge clk);
    #1;
  endtask

  // opening flag, optional junk then reset command, data + check field, closing flag
  task automatic runFrame(input int nData, input logic genPre, input logic chkPre,
                          input int flip, input int junk, input logic bitOnFlag);
    logic [15:0] c;
    logic bits [0:127];
    int total;
    c = genPre ? 16'hFFFF : 16'h0000;
    for (int i = 0; i < nData; i++) begin
      bits[i] = nextRand();
      c = crcStep(c, bits[i]);
    end
    for (int k = 0; k < 16; k++) bits[nData + k] = ~c[15 - k];
    total = nData + 16;
    if (flip >= 0 && flip < total) bits[flip] = ~bits[flip];
    presetOnes = chkPre;
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int j = 0; j < junk; j++) step(1'b1, nextRand(), 1'b0, 1'b0, 1'b0);
    if (junk > 0) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);  // R10 bit dropped
    for (int i = 0; i < total; i++) begin
      step(1'b1, bits[i], 1'b0, 1'b0, 1'b0);
      if (i % 3 == 2) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    end
    step(bitOnFlag, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R11 reset state
    check(frameDone == 1'b0 && crcError == 1'b0 && residue == 3'b000, "R11 reset",
          {12'h0, frameDone, crcError, residue[1:0]}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      runFrame(int'(VECS[v].nData), VECS[v].genPre, VECS[v].chkPre,
               (VECS[v].flip == 8'd255) ? -1 : int'(VECS[v].flip), 0, 1'b0);
      check(frameDone == 1'b1, $sformatf("R7 vec%0d frameDone", v), 16'(frameDone), 16'h1);
      check(crcError == VECS[v].expErr, $sformatf("R1 R2 R3 vec%0d crcError", v),
            16'(crcError), 16'(VECS[v].expErr));
      check(residue == VECS[v].expRes, $sformatf("R9 vec%0d residue", v),
            16'(residue), 16'(VECS[v].expRes));
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check(frameDone == 1'b0, $sformatf("R7 vec%0d pulse width", v), 16'(frameDone), 16'h0);
    end

    // R7 opening flags with no bits give no frameDone
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check(frameDone == 1'b0, "R7 empty flag", 16'(frameDone), 16'h0);

    // R8 results held through bits, flags and hunt
    runFrame(13, 1'b1, 1'b1, 2, 0, 1'b0);
    check(crcError == 1'b1 && residue == 3'b001, "R2 R9 bad frame",
          {12'h0, crcError, residue}, 16'h9);
    for (int i = 0; i < 10; i++) step(1'b1, nextRand(), 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(crcError == 1'b1 && residue == 3'b001 && frameDone == 1'b0, "R8 hold",
          {11'h0, frameDone, crcError, residue}, 16'h9);

    // R5 hunt mid-frame abandons the frame; bit during hunt ignored (R10)
    presetOnes = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, nextRand(), 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check(frameDone == 1'b0, "R5 hunt abort", 16'(frameDone), 16'h0);
    runFrame(20, 1'b1, 1'b1, -1, 0, 1'b0);
    check(frameDone == 1'b1 && crcError == 1'b0 && residue == expResidue(20),
          "R5 frame after hunt", {11'h0, frameDone, crcError, residue},
          {11'h0, 1'b1, 1'b0, expResidue(20)});

    // R6 reset command presets but keeps bit count; coincident bit dropped (R10)
    runFrame(8, 1'b0, 1'b0, -1, 5, 1'b0);
    check(crcError == 1'b0, "R6 reset command remainder", 16'(crcError), 16'h0);
    check(residue == 3'b001, "R6 R10 count kept", 16'(residue), 16'h1);

    // R10 bit coincident with closing flag ignored
    runFrame(11, 1'b1, 1'b1, -1, 0, 1'b1);
    check(frameDone == 1'b1 && crcError == 1'b0 && residue == 3'b010,
          "R10 bit on flag", {11'h0, frameDone, crcError, residue}, 16'h12);

    // R4 back-to-back frames with only flag presets, zero preset
    runFrame(27, 1'b0, 1'b0, -1, 0, 1'b0);
    runFrame(30, 1'b0, 1'b0, -1, 0, 1'b0);
    check(crcError == 1'b0 && residue == expResidue(30), "R4 consecutive frames",
          {12'h0, crcError, residue}, {12'h0, 1'b0, expResidue(30)});

    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule